// File: doc/BRIEF.md
# Frame Average Brightness Meter

This block watches a pixel stream of 8-bit red, green and blue samples and estimates how bright each frame is. Every pixel that falls inside the active picture window is turned into an approximate luminance value and added into a per-frame sum. When the vertical sync pulse arrives, the sum is scaled to a 16-step level, and the sum starts again from zero for the next frame.

Two 4-bit levels are registered at each frame boundary. The first is the raw measured brightness. The second is the same level limited by a 16-step control value: the larger the control value, the lower the ceiling. A peak-luminance controller downstream uses these levels to decide how hard to drive the panel. When the blanking input is high, the pixels presented are treated as black. They still count toward the frame's pixel total.

Top module: `apl_meter`

## Requirements
- R1: Each pixel's luminance is floor((2*R + 5*G + B) / 8), giving 0..255.
- R2: A pixel presented while `blank` is high contributes luminance 0. It still counts as one of the frame's active pixels.
- R3: The first falling edge of `hsync_n` after a falling edge of `vsync_n` begins active line 1. Only lines 1..V_ACTIVE are accumulated, and within each line only the first H_ACTIVE cycles with `pix_en` high after the `hsync_n` falling edge. A pixel strobe in the same cycle as a sync falling edge is ignored.
- R4: `apl_raw` = floor(S / (16 * H_ACTIVE * V_ACTIVE)), where S is the luminance sum of the frame that just ended. It is registered on the clock edge at which `vsync_n` is first seen low, so it is visible from the following cycle.
- R5: Outside that update edge, `apl_raw` and `apl_level` hold their values.
- R6: `apl_level` = min(`apl_raw`, 15 - `limit`). `limit` is sampled only on the update edge, and changes at other times have no effect on either output.
- R7: The frame sum restarts from zero at every update. A full-white frame gives level 15 without overflow.
- R8: After reset, both `apl_raw` and `apl_level` read 0.
- R9: All 4-bit levels and `limit` are unsigned, with bit 3 as the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | A pixel is present on the colour inputs this cycle |
| hsync_n | input | 1 | Horizontal sync, active-low pulse |
| vsync_n | input | 1 | Vertical sync, active-low pulse; its falling edge ends the frame |
| blank | input | 1 | High: the current pixel is treated as black |
| red | input | 8 | Red sample, bit 7 MSB |
| green | input | 8 | Green sample, bit 7 MSB |
| blue | input | 8 | Blue sample, bit 7 MSB |
| limit | input | 4 | Brightness limit control, 0 = no limit, 15 = level forced to 0 |
| apl_raw | output | 4 | Measured frame-average level |
| apl_level | output | 4 | Measured level capped by 15 - limit |

## Verification
The hardest case to reach is proving that pixels outside the window are excluded. Extra pixels past the line width and extra lines past the frame height leave no trace in the outputs. The stimulus therefore fills the window with black and drives bright pixels beyond it on both axes, and the result must still be level 0. Single-primary frames separate the three colour weights. A frame with every other pixel blanked lands mid-scale and shows that blanked pixels still count toward the total. The limit input is toggled just after each update to show that it has no effect until the next one.

// File: rtl/apl_pkg.sv
package apl_pkg;

    typedef logic [3:0] apl_lvl_t;

    localparam apl_lvl_t LVL_TOP = 4'd15;

    function automatic apl_lvl_t lvl_min(input apl_lvl_t a, input apl_lvl_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/apl_luma.sv
module apl_luma (
    input  logic [7:0] red,
    input  logic [7:0] green,
    input  logic [7:0] blue,
    input  logic       blank,
    output logic [7:0] luma
);
    logic [10:0] weighted;

    always_comb begin
        weighted = {2'b00, red, 1'b0}
                 + ({3'b000, green} << 2) + {3'b000, green}
                 + {3'b000, blue};
        luma = blank ? 8'd0 : weighted[10:3];
    end
endmodule

// File: rtl/apl_window.sv
module apl_window #(
    parameter int H_ACTIVE = 853,
    parameter int V_ACTIVE = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n,
    input  logic vsync_n,
    input  logic pix_en,
    output logic frame_end,
    output logic pix_active
);
    localparam int COL_W  = $clog2(H_ACTIVE + 1);
    localparam int LINE_W = $clog2(V_ACTIVE + 2);
    localparam logic [COL_W-1:0]  COL_END   = COL_W'(H_ACTIVE);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_ACTIVE);

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
        logic              hs_prev;
        logic              vs_prev;
    } win_t;

    win_t st_d, st_q;
    logic line_start;

    always_comb begin
        st_d         = st_q;
        st_d.hs_prev = hsync_n;
        st_d.vs_prev = vsync_n;
        frame_end    = st_q.vs_prev & ~vsync_n;
        line_start   = st_q.hs_prev & ~hsync_n;
        pix_active   = 1'b0;
        if (frame_end) begin
            st_d.line = '0;
            st_d.col  = COL_END;
        end else if (line_start) begin
            st_d.col = '0;
            if (st_q.line <= LINE_LAST) begin
                st_d.line = st_q.line + 1'b1;
            end
        end else if (pix_en && (st_q.col != COL_END)) begin
            st_d.col   = st_q.col + 1'b1;
            pix_active = (st_q.line != '0) && (st_q.line <= LINE_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.col     <= COL_END;
            st_q.line    <= '0;
            st_q.hs_prev <= 1'b1;
            st_q.vs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/apl_norm.sv
module apl_norm
    import apl_pkg::*;
#(
    parameter int SUM_W = 27,
    parameter int PIX_N = 409440
) (
    input  logic [SUM_W-1:0] sum,
    input  apl_lvl_t         limit,
    output apl_lvl_t         raw,
    output apl_lvl_t         capped
);
    localparam longint DIVISOR = longint'(PIX_N) * 16;

    logic [SUM_W-1:0] quot;
    apl_lvl_t         ceiling;

    always_comb begin
        quot    = sum / SUM_W'(DIVISOR);
        raw     = (quot > SUM_W'(LVL_TOP)) ? LVL_TOP : quot[3:0];
        ceiling = LVL_TOP - limit;
        capped  = lvl_min(raw, ceiling);
    end
endmodule

// File: rtl/apl_meter.sv
module apl_meter
    import apl_pkg::*;
#(
    parameter int H_ACTIVE = 853,
    parameter int V_ACTIVE = 480
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_en,
    input  logic       hsync_n,
    input  logic       vsync_n,
    input  logic       blank,
    input  logic [7:0] red,
    input  logic [7:0] green,
    input  logic [7:0] blue,
    input  logic [3:0] limit,
    output logic [3:0] apl_raw,
    output logic [3:0] apl_level
);
    localparam int PIX_N = H_ACTIVE * V_ACTIVE;
    localparam int SUM_W = $clog2(PIX_N * 255 + 1);

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        apl_lvl_t         raw;
        apl_lvl_t         lvl;
    } meter_t;

    meter_t st_d, st_q;

    logic       frame_end;
    logic       pix_active;
    logic [7:0] luma;
    apl_lvl_t   norm_raw;
    apl_lvl_t   norm_cap;
    logic [SUM_W-1:0] acc_view;

    apl_luma luma_i (
        .red   (red),
        .green (green),
        .blue  (blue),
        .blank (blank),
        .luma  (luma)
    );

    apl_window #(
        .H_ACTIVE (H_ACTIVE),
        .V_ACTIVE (V_ACTIVE)
    ) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_n    (hsync_n),
        .vsync_n    (vsync_n),
        .pix_en     (pix_en),
        .frame_end  (frame_end),
        .pix_active (pix_active)
    );

    apl_norm #(
        .SUM_W (SUM_W),
        .PIX_N (PIX_N)
    ) norm_i (
        .sum    (st_q.acc),
        .limit  (limit),
        .raw    (norm_raw),
        .capped (norm_cap)
    );

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.acc = '0;
            st_d.raw = norm_raw;
            st_d.lvl = norm_cap;
        end else if (pix_active) begin
            st_d.acc = st_q.acc + SUM_W'(luma);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign apl_raw   = st_q.raw;
    assign apl_level = st_q.lvl;
    assign acc_view  = st_q.acc;
endmodule

// File: rtl/apl_meter_chk.sv
module apl_meter_chk #(
    parameter int SUM_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vsync_n,
    input logic             pix_en,
    input logic [3:0]       limit,
    input logic [3:0]       apl_raw,
    input logic [3:0]       apl_level,
    input logic [SUM_W-1:0] acc
);
    logic vs_seen_q;
    logic upd;

    always_ff @(posedge clk) begin
        if (!rst_n) vs_seen_q <= 1'b1;
        else        vs_seen_q <= vsync_n;
    end

    assign upd = vs_seen_q & ~vsync_n;

    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(apl_raw)); // R5
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(apl_level)); // R5
    AST_LEVEL_UNDER_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> apl_level <= apl_raw); // R6
    AST_LEVEL_UNDER_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> apl_level <= (4'd15 - $past(limit))); // R6
    AST_SUM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> acc == '0); // R7
    AST_SUM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_n && !pix_en) |=> $stable(acc)); // R3
endmodule

bind apl_meter apl_meter_chk #(.SUM_W(SUM_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_n   (vsync_n),
    .pix_en    (pix_en),
    .limit     (limit),
    .apl_raw   (apl_raw),
    .apl_level (apl_level),
    .acc       (acc_view)
);

// File: tb/apl_meter_tb_top.sv
module apl_meter_tb_top;
    localparam int H = 8;
    localparam int V = 4;
    localparam int N = H * V;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       hsync_n = 1'b1;
    logic       vsync_n = 1'b1;
    logic       blank = 1'b0;
    logic [7:0] red = 8'd0;
    logic [7:0] green = 8'd0;
    logic [7:0] blue = 8'd0;
    logic [3:0] limit = 4'd0;
    logic [3:0] apl_raw;
    logic [3:0] apl_level;

    always #5 clk = ~clk;

    apl_meter #(.H_ACTIVE(H), .V_ACTIVE(V)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .blank(blank), .red(red), .green(green),
        .blue(blue), .limit(limit), .apl_raw(apl_raw), .apl_level(apl_level)
    );

    typedef struct {
        int    raw;
        int    lvl;
        string req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   cur_raw = 0;
    int   cur_lvl = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // pixel pattern: {blank, r, g, b}
    function automatic logic [24:0] pixel(input int mode, input int l, input int c);
        logic [7:0] v;
        case (mode)
            0: return {1'b0, 8'd255, 8'd255, 8'd255};
            1: return {1'b0, 8'd0, 8'd0, 8'd0};
            2: return {1'b0, 8'd0, 8'd0, 8'd255};
            3: return {1'b0, 8'd255, 8'd0, 8'd0};
            4: return {1'b0, 8'd0, 8'd255, 8'd0};
            5: return {(c % 2) == 1, 8'd255, 8'd255, 8'd255};
            6: return (l < V && c < H) ? {1'b0, 24'd0} : {1'b0, 24'hFFFFFF};
            default: begin
                v = 8'((c * 37 + l * 11) % 256);
                return {1'b0, v, v, v};
            end
        endcase
    endfunction

    function automatic int lum_of(input logic [24:0] p);
        if (p[24]) return 0;
        return (2 * int'(p[23:16]) + 5 * int'(p[15:8]) + int'(p[7:0])) / 8;
    endfunction

    task automatic frame_end(input int lim, input int raw, input int lvl, input string req);
        exp_t e;
        e.raw = raw;
        e.lvl = (raw < 15 - lim) ? raw : 15 - lim;
        e.req = req;
        q.push_back(e);
        @(negedge clk);
        limit   = 4'(lim);
        vsync_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        vsync_n = 1'b1;
        limit   = ~4'(lim);
        repeat (3) @(negedge clk);
        // R6: limit moved after the update edge, outputs must not follow
        check("R6", int'(apl_level), e.lvl);
        check("R5", int'(apl_raw), e.raw);
        cur_raw = e.raw;
        cur_lvl = e.lvl;
        if (lvl < 0) begin
            check("R6", e.lvl, e.lvl);
        end
    endtask

    task automatic run_frame(input int mode, input int lim, input int xl, input int xc, input string req);
        int sum = 0;
        logic [24:0] p;
        for (int l = 0; l < V + xl; l++) begin
            @(negedge clk);
            hsync_n = 1'b0;
            pix_en  = 1'b0;
            @(negedge clk);
            hsync_n = 1'b1;
            for (int c = 0; c < H + xc; c++) begin
                @(negedge clk);
                p      = pixel(mode, l, c);
                blank  = p[24];
                red    = p[23:16];
                green  = p[15:8];
                blue   = p[7:0];
                pix_en = 1'b1;
                if (l < V && c < H) sum += lum_of(p);
            end
            @(negedge clk);
            pix_en = 1'b0;
            blank  = 1'b0;
            if (l == 1) begin
                check("R5", int'(apl_raw), cur_raw);
                check("R5", int'(apl_level), cur_lvl);
            end
        end
        frame_end(lim, sum / (16 * N), 0, req);
    endtask

    // monitor: pops one expected item per observed vsync falling edge
    initial begin
        logic vsp = 1'b1;
        exp_t e;
        forever begin
            @(posedge clk);
            if (rst_n && vsp && !vsync_n) begin
                vsp = vsync_n;
                @(negedge clk);
                if (q.size() == 0) begin
                    check("R4", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(e.req, int'(apl_raw), e.raw);
                    check("R6", int'(apl_level), e.lvl);
                end
            end else begin
                vsp = vsync_n;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R8", int'(apl_raw), 0);
        check("R8", int'(apl_level), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", int'(apl_raw), 0);
        check("R8", int'(apl_level), 0);
        frame_end(0, 0, 0, "R8");            // sync pulse, empty sum
        run_frame(0, 0, 0, 0, "R7");         // full white -> 15
        run_frame(1, 0, 0, 0, "R7");         // black right after white: sum cleared
        run_frame(2, 0, 0, 0, "R1");         // blue only: lum 31 -> 1
        run_frame(3, 0, 0, 0, "R1");         // red only: lum 63 -> 3
        run_frame(4, 10, 0, 0, "R1");        // green only: lum 159 -> 9, capped 5
        run_frame(0, 5, 0, 0, "R9");         // 15 capped to 10
        run_frame(5, 0, 0, 0, "R2");         // half blanked -> 7
        run_frame(6, 0, 2, 3, "R3");         // bright only outside window -> 0
        run_frame(7, 15, 0, 0, "R4");        // gradient, limit 15 forces 0
        run_frame(7, 3, 1, 2, "R4");         // gradient with extras outside window
        repeat (5) @(negedge clk);
        check("R4", q.size(), 0);
        finish_up();
    end
endmodule